// File: doc/BRIEF.md
# Retirement Order Sequence Checker

This block is a passive monitor for a processor's retirement trace. Each cycle, up to NRET channels may each report one retired instruction together with its 64-bit sequence index. The checker confirms that every index shows up exactly once and that no index is skipped. Instructions may retire out of index order. The checker accepts this while the index lies within a bounded window above the lowest index still missing.

The trace may also announce a speculative rollback to a given index. Indices at or above that point that were reported in earlier cycles are forgotten and must be reported again. Packets that arrive in the same cycle as the rollback already belong to the restarted stream. The first violation sets a sticky flag and records its cause. The lowest index still awaited is always visible, so a surrounding formal or simulation environment can track progress.

Top module: `retire_order_checker`

## Requirements
- R1: After reset, nextExpected is 0, errFlag is 0 and errCode is 0 (code 0 means no error).
- R2: When the channels report consecutive indices starting at nextExpected, nextExpected rises by the number of valid packets on the clock edge that captures them, and no error is raised.
- R3: A channel whose valid bit is low has no effect, whatever its index field holds.
- R4: An index that lies above nextExpected but inside the window (offset below WINDOW) is accepted without error. nextExpected stays at the lowest index not yet reported, and jumps past the whole contiguous run once the gap is filled.
- R5: An index below nextExpected, an index already reported inside the window, or the same index on two channels in one cycle sets errFlag with errCode 1 (duplicate).
- R6: An index at or beyond nextExpected + WINDOW sets errFlag with errCode 2 (out of window). Offset WINDOW-1 is still accepted.
- R7: A rollback to index r, with r not below nextExpected, forgets earlier-reported indices at or above r, so they may be reported again without error. Indices below r stay recorded.
- R8: Packets in the cycle of a rollback are applied after the forgetting, so re-reporting index r in that cycle is legal.
- R9: A rollback to an index below nextExpected sets errFlag with errCode 3.
- R10: errFlag and errCode hold until reset, and later violations do not change the code. Within one cycle the priority is code 3, then code 1, then code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retValid | input | NRET | Per-channel retirement valid |
| retOrder | input | NRET*ORDER_W | Per-channel sequence index, channel c in bits c*ORDER_W upward |
| rbValid | input | 1 | Rollback request |
| rbOrder | input | ORDER_W | First index invalidated by the rollback |
| errFlag | output | 1 | Sticky violation flag |
| errCode | output | 2 | Cause of first violation: 0 none, 1 duplicate, 2 out of window, 3 rollback below base |
| nextExpected | output | ORDER_W | Lowest index not yet retired |

## Verification
The hardest situation to reach is a rollback that lands between indices already held in the window. In that case some recorded entries must survive and others must be dropped, and nextExpected then moves only as far as the survivors allow. The stimulus first retires a gap-leaving pattern (indices 0, 1, 4, 5). It then rolls back to 5 and fills the gap. It checks that nextExpected stops at 5, which shows that 4 survived and 5 was forgotten. A second sequence places a rollback and a re-report of the same index in one cycle, which exercises the clear-then-set ordering.

// File: rtl/ordchk_pkg.sv
package ordchk_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_DUP    = 2'd1,
    ERR_WINDOW = 2'd2,
    ERR_RB_LOW = 2'd3
  } errCode_e;

  // strobes from the decision logic to the tracking window
  typedef struct packed {
    logic rbApply;    // rollback at or above base: clear upper entries
    logic anyAccept;  // at least one packet marks the window
  } winStrobe_t;

endpackage

// File: rtl/ordchk_window.sv
module ordchk_window
  import ordchk_pkg::*;
#(
  parameter int NRET    = 2,
  parameter int ORDER_W = 64,
  parameter int WINDOW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  winStrobe_t              strb,
  input  logic [NRET-1:0]         acceptVec,
  input  logic [NRET*ORDER_W-1:0] retOrder,
  input  logic                    rbValid,
  input  logic [ORDER_W-1:0]      rbOrder,
  output logic [ORDER_W-1:0]      base,
  output logic [WINDOW-1:0]       keptMap
);

  localparam int IDX_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [WINDOW-1:0]  seenMap;
  logic [WINDOW-1:0]  keepMask;
  logic [WINDOW-1:0]  setMask;
  logic [WINDOW-1:0]  mergedMap;
  logic [WINDOW-1:0]  nextMap;
  logic [CNT_W-1:0]   runLen;
  logic [ORDER_W-1:0] rbOff;
  logic               rbInside;

  // entries at or above the rollback point are forgotten
  always_comb begin
    rbOff    = rbOrder - base;
    rbInside = rbValid && (rbOrder >= base);
    for (int i = 0; i < WINDOW; i++) begin
      keepMask[i] = !rbInside || (ORDER_W'(i) < rbOff);
    end
    keptMap = seenMap & keepMask;
  end

  // mark accepted packets after the rollback clear
  always_comb begin
    setMask = '0;
    for (int c = 0; c < NRET; c++) begin
      if (acceptVec[c]) begin
        setMask[IDX_W'(retOrder[c*ORDER_W +: ORDER_W] - base)] = 1'b1;
      end
    end
    mergedMap = keptMap | setMask;
  end

  // slide over the contiguous run of completed indices
  always_comb begin
    logic stop;
    stop   = 1'b0;
    runLen = '0;
    for (int i = 0; i < WINDOW; i++) begin
      if (!stop) begin
        if (mergedMap[i]) runLen = runLen + CNT_W'(1);
        else              stop   = 1'b1;
      end
    end
    nextMap = mergedMap >> runLen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      seenMap <= '0;
    end else if (strb.anyAccept || strb.rbApply) begin
      base    <= base + ORDER_W'(runLen);
      seenMap <= nextMap;
    end
  end

  // R2: the base never moves backwards
  a_r2_base_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    base >= $past(base));

  // R4: the slot at the base is always the missing one
  a_r4_base_slot_open: assert property (@(posedge clk) disable iff (!rst_n)
    !seenMap[0]);

  // R4: one cycle never advances past the whole window
  a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (base - $past(base)) <= ORDER_W'(WINDOW));

endmodule

// File: rtl/ordchk_ctrl.sv
module ordchk_ctrl
  import ordchk_pkg::*;
#(
  parameter int NRET    = 2,
  parameter int ORDER_W = 64,
  parameter int WINDOW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRET-1:0]         retValid,
  input  logic [NRET*ORDER_W-1:0] retOrder,
  input  logic                    rbValid,
  input  logic [ORDER_W-1:0]      rbOrder,
  input  logic [ORDER_W-1:0]      base,
  input  logic [WINDOW-1:0]       keptMap,
  output winStrobe_t              strb,
  output logic [NRET-1:0]         acceptVec,
  output logic                    errFlag,
  output errCode_e                errCode
);

  localparam int IDX_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic     anyDup;
  logic     anyOver;
  logic     rbLow;
  errCode_e cycCode;

  always_comb begin
    logic [WINDOW-1:0]  taken;
    logic [ORDER_W-1:0] ord;
    logic [ORDER_W-1:0] diff;
    logic               below;
    logic               over;
    taken     = keptMap;
    acceptVec = '0;
    anyDup    = 1'b0;
    anyOver   = 1'b0;
    for (int c = 0; c < NRET; c++) begin
      ord   = retOrder[c*ORDER_W +: ORDER_W];
      diff  = ord - base;
      below = ord < base;
      over  = !below && (diff >= ORDER_W'(WINDOW));
      if (retValid[c]) begin
        if (below)                         anyDup  = 1'b1;
        else if (over)                     anyOver = 1'b1;
        else if (taken[IDX_W'(diff)])      anyDup  = 1'b1;
        else begin
          acceptVec[c]        = 1'b1;
          taken[IDX_W'(diff)] = 1'b1;
        end
      end
    end
    rbLow          = rbValid && (rbOrder < base);
    strb.rbApply   = rbValid && !rbLow;
    strb.anyAccept = |acceptVec;
    if (rbLow)        cycCode = ERR_RB_LOW;
    else if (anyDup)  cycCode = ERR_DUP;
    else if (anyOver) cycCode = ERR_WINDOW;
    else              cycCode = ERR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
    end else if (!errFlag && (cycCode != ERR_NONE)) begin
      errFlag <= 1'b1;
      errCode <= cycCode;
    end
  end

  // R10: flag is sticky
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);

  // R10: first cause is kept
  a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> $stable(errCode));

  // R1: no cause without the flag
  a_r1_code_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !errFlag |-> (errCode == ERR_NONE));

  // R9: low rollback always ends in an error
  a_r9_rb_low_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rbValid && (rbOrder < base)) |=> errFlag);

  for (genvar g = 0; g < NRET; g++) begin : g_chan
    // R6: far index always ends in an error
    a_r6_far_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (retValid[g] && (retOrder[g*ORDER_W +: ORDER_W] >= base + ORDER_W'(WINDOW)))
        |=> errFlag);
    // R5: index below base always ends in an error
    a_r5_below_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (retValid[g] && (retOrder[g*ORDER_W +: ORDER_W] < base)) |=> errFlag);
  end

endmodule

// File: rtl/retire_order_checker.sv
module retire_order_checker
  import ordchk_pkg::*;
#(
  parameter int NRET    = 2,
  parameter int ORDER_W = 64,
  parameter int WINDOW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRET-1:0]         retValid,
  input  logic [NRET*ORDER_W-1:0] retOrder,
  input  logic                    rbValid,
  input  logic [ORDER_W-1:0]      rbOrder,
  output logic                    errFlag,
  output logic [1:0]              errCode,
  output logic [ORDER_W-1:0]      nextExpected
);

  winStrobe_t         strb;
  logic [NRET-1:0]    acceptVec;
  logic [ORDER_W-1:0] base;
  logic [WINDOW-1:0]  keptMap;
  errCode_e           codeQ;

  ordchk_ctrl #(.NRET(NRET), .ORDER_W(ORDER_W), .WINDOW(WINDOW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .retValid  (retValid),
    .retOrder  (retOrder),
    .rbValid   (rbValid),
    .rbOrder   (rbOrder),
    .base      (base),
    .keptMap   (keptMap),
    .strb      (strb),
    .acceptVec (acceptVec),
    .errFlag   (errFlag),
    .errCode   (codeQ)
  );

  ordchk_window #(.NRET(NRET), .ORDER_W(ORDER_W), .WINDOW(WINDOW)) i_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .acceptVec (acceptVec),
    .retOrder  (retOrder),
    .rbValid   (rbValid),
    .rbOrder   (rbOrder),
    .base      (base),
    .keptMap   (keptMap)
  );

  assign errCode      = codeQ;
  assign nextExpected = base;

endmodule

// File: tb/test_retire_order_checker.sv
module test_retire_order_checker;

  localparam int NRET    = 2;
  localparam int ORDER_W = 64;
  localparam int WINDOW  = 16;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NRET-1:0]         retValid = '0;
  logic [NRET*ORDER_W-1:0] retOrder = '0;
  logic                    rbValid = 1'b0;
  logic [ORDER_W-1:0]      rbOrder = '0;
  logic                    errFlag;
  logic [1:0]              errCode;
  logic [ORDER_W-1:0]      nextExpected;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  retire_order_checker #(.NRET(NRET), .ORDER_W(ORDER_W), .WINDOW(WINDOW)) i_retire_order_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .retValid     (retValid),
    .retOrder     (retOrder),
    .rbValid      (rbValid),
    .rbOrder      (rbOrder),
    .errFlag      (errFlag),
    .errCode      (errCode),
    .nextExpected (nextExpected)
  );

  task automatic doReset();
    @(negedge clk);
    rst_n    = 1'b0;
    retValid = '0;
    rbValid  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one cycle at a negedge, return at the next negedge
  task automatic send(input logic v0, input logic [63:0] o0,
                      input logic v1, input logic [63:0] o1,
                      input logic rb, input logic [63:0] rbo);
    retValid = {v1, v0};
    retOrder = {o1, o0};
    rbValid  = rb;
    rbOrder  = rbo;
    @(negedge clk);
    retValid = '0;
    rbValid  = 1'b0;
  endtask

  task automatic one(input logic [63:0] o);
    send(1'b1, o, 1'b0, 64'd0, 1'b0, 64'd0);
  endtask

  task automatic chk(input string req, input logic [63:0] expNext,
                     input logic expFlag, input logic [1:0] expCode);
    checks++;
    if (nextExpected !== expNext || errFlag !== expFlag || errCode !== expCode) begin
      errors++;
      $display("FAIL %s: next=%0d flag=%0b code=%0d expected next=%0d flag=%0b code=%0d",
               req, nextExpected, errFlag, errCode, expNext, expFlag, expCode);
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1 reset state", 64'd0, 1'b0, 2'd0);
  endtask

  task automatic testInOrder();
    doReset();
    send(1'b1, 64'd0, 1'b1, 64'd1, 1'b0, 64'd0);
    chk("R2 two in order", 64'd2, 1'b0, 2'd0);
    send(1'b0, 64'd77, 1'b1, 64'd2, 1'b0, 64'd0);
    chk("R3 invalid ch0 far index ignored", 64'd3, 1'b0, 2'd0);
    send(1'b0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0);
    chk("R3 invalid stale index ignored", 64'd3, 1'b0, 2'd0);
  endtask

  task automatic testReorder();
    one(64'd5);
    chk("R4 gap held", 64'd3, 1'b0, 2'd0);
    one(64'd4);
    chk("R4 gap still held", 64'd3, 1'b0, 2'd0);
    one(64'd3);
    chk("R4 run completes", 64'd6, 1'b0, 2'd0);
    send(1'b1, 64'd7, 1'b1, 64'd6, 1'b0, 64'd0);
    chk("R4 swapped pair", 64'd8, 1'b0, 2'd0);
  endtask

  task automatic testDup();
    one(64'd4);
    chk("R5 below base", 64'd8, 1'b1, 2'd1);
    one(64'd100);
    chk("R10 later error keeps code", 64'd8, 1'b1, 2'd1);
    doReset();
    send(1'b1, 64'd0, 1'b1, 64'd0, 1'b0, 64'd0);
    chk("R5 same cycle pair", 64'd1, 1'b1, 2'd1);
    doReset();
    one(64'd3);
    one(64'd3);
    chk("R5 in window repeat", 64'd0, 1'b1, 2'd1);
  endtask

  task automatic testWindow();
    doReset();
    one(64'd15);
    chk("R6 last slot accepted", 64'd0, 1'b0, 2'd0);
    one(64'd16);
    chk("R6 first slot beyond", 64'd0, 1'b1, 2'd2);
  endtask

  task automatic testRollback();
    doReset();
    send(1'b1, 64'd0, 1'b1, 64'd1, 1'b0, 64'd0);
    send(1'b1, 64'd4, 1'b1, 64'd5, 1'b0, 64'd0);
    chk("R7 pre rollback", 64'd2, 1'b0, 2'd0);
    send(1'b0, 64'd0, 1'b0, 64'd0, 1'b1, 64'd5);
    chk("R7 rollback alone", 64'd2, 1'b0, 2'd0);
    send(1'b1, 64'd2, 1'b1, 64'd3, 1'b0, 64'd0);
    chk("R7 lower entry kept", 64'd5, 1'b0, 2'd0);
    one(64'd5);
    chk("R7 forgotten index re-reported", 64'd6, 1'b0, 2'd0);
  endtask

  task automatic testRbSame();
    doReset();
    one(64'd0);
    one(64'd3);
    send(1'b1, 64'd3, 1'b0, 64'd0, 1'b1, 64'd3);
    chk("R8 same cycle re-report", 64'd1, 1'b0, 2'd0);
    send(1'b1, 64'd1, 1'b1, 64'd2, 1'b0, 64'd0);
    chk("R8 entry set after clear", 64'd4, 1'b0, 2'd0);
    send(1'b1, 64'd4, 1'b0, 64'd0, 1'b1, 64'd4);
    chk("R8 rollback at base", 64'd5, 1'b0, 2'd0);
  endtask

  task automatic testRbLow();
    doReset();
    send(1'b1, 64'd0, 1'b1, 64'd1, 1'b0, 64'd0);
    send(1'b0, 64'd0, 1'b0, 64'd0, 1'b1, 64'd1);
    chk("R9 rollback below base", 64'd2, 1'b1, 2'd3);
  endtask

  task automatic testPriority();
    doReset();
    one(64'd0);
    send(1'b1, 64'd0, 1'b0, 64'd0, 1'b1, 64'd0);
    chk("R10 rollback cause wins", 64'd1, 1'b1, 2'd3);
    doReset();
    one(64'd0);
    send(1'b1, 64'd40, 1'b1, 64'd0, 1'b0, 64'd0);
    chk("R10 duplicate beats window", 64'd1, 1'b1, 2'd1);
  endtask

  task automatic testFullWindow();
    doReset();
    for (int k = 1; k < WINDOW; k++) one(64'(k));
    chk("R4 fifteen pending", 64'd0, 1'b0, 2'd0);
    one(64'd0);
    chk("R4 full window slide", 64'd16, 1'b0, 2'd0);
    one(64'd31);
    chk("R6 last slot after slide", 64'd16, 1'b0, 2'd0);
    one(64'd32);
    chk("R6 beyond after slide", 64'd16, 1'b1, 2'd2);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testInOrder();
    testReorder();
    testDup();
    testWindow();
    testRollback();
    testRbSame();
    testRbLow();
    testPriority();
    testFullWindow();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

endmodule